// File: doc/BRIEF.md
# 2D Blitter Drawing Engine

This block draws rectangles into an on-chip 8-bit-per-pixel framebuffer. A host programs a small register file with a control word, packed source and destination coordinates, a packed size, a foreground colour and an 8-bit raster-operation code. It then launches either a screen-to-screen rectangle copy or a solid rectangle fill. Every destination pixel becomes a bitwise ternary function of pattern (the foreground colour), source and the current destination value. Either axis can be walked backwards, so overlapping copies can be ordered safely.

A launch comes from an explicit start bit in the control word, or from a quick-start mode in which a write to one selected register starts the operation. While an operation runs, the host port is stalled: `host_ready` is low, and register or pixel writes presented in that time are not taken. A pixel port gives the host direct reads and writes of the framebuffer while the engine is idle.

The controller is a five-state machine:
- IDLE: serves host accesses. A launching write moves it to LAUNCH.
- LAUNCH: validates the programmed operation. An invalid or empty operation returns to IDLE. Otherwise it enters RD_SRC for a copy, or RD_DST for a fill.
- RD_SRC: reads the source pixel, then moves to RD_DST.
- RD_DST: reads the destination pixel, then moves to WR_PIX.
- WR_PIX: writes the result. After the last pixel it returns to IDLE. Otherwise it starts the next pixel at RD_SRC (copy) or RD_DST (fill).

Top module: `blit_engine`

## Requirements
- R1: After reset `host_ready` is 1 and `status` is 3'b000.
- R2: `reg_sel` picks the register: 0 control, 1 source, 2 destination, 3 size, 4 foreground (low 8 bits), 5 ROP (low 8 bits). Source, destination and size hold y (or height) in bits 31:16 and x (or width) in bits 15:0. A pixel (x, y) lives at framebuffer address (y*pitch + x) modulo FB_WORDS, with 16-bit coordinate arithmetic.
- R3: Writing the control register with bit 31 set launches an operation using the newly written fields.
- R4: Control bits 30:29 pick the quick-start register: 1 size, 2 source, 3 destination, 0 none. An accepted write to the picked register launches an operation. Writes to any other register never launch.
- R5: Command 0x01 in control bits 5:0 is a copy. Pixels are visited with x inner and y outer, and each one is read and then written before the next is read. The new destination value is ROP(foreground, source, destination).
- R6: Command 0x02 is a fill. Both the source and the pattern inputs of the ROP are the foreground colour.
- R7: Control bit 6 reverses the x walk and bit 7 reverses the y walk. The programmed coordinate is then the last pixel on that axis, and later pixels lie at decreasing coordinates.
- R8: Result bit i equals rop[4*p + 2*s + d], where p, s and d are bit i of pattern, source and destination.
- R9: A launch is rejected, leaving the framebuffer unchanged and `host_ready` high again two cycles after the launching write, in any of these cases: the command is not 0x01 or 0x02; the depth field (bits 16:14) is not 1; the pitch code (bits 26:24) is not one of 1=640, 2=800, 4=1024, 5=1152, 6=1280, 7=1600.
- R10: A width or height of zero writes nothing, and `host_ready` is high again two cycles after the launching write.
- R11: While an operation runs, `host_ready` is 0 and `status[2]` is 1. `status[0]` is 1 during pixel reads. `status` is 0 whenever `host_ready` is 1. Writes presented while `host_ready` is 0 have no effect.
- R12: When `host_ready` is 1, `pix_we` writes `pix_wdata` at `pix_addr`. `pix_rdata` returns the word at the `pix_addr` sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| pix_we | input | 1 | Framebuffer write strobe |
| pix_addr | input | ADDR_W (11) | Framebuffer word address |
| pix_wdata | input | PIX_W (8) | Framebuffer write data |
| pix_rdata | output | PIX_W (8) | Framebuffer read data, one cycle after the address |
| host_ready | output | 1 | Host port accepts accesses (engine idle) |
| status | output | 3 | Bit 2 engine busy, bit 0 pixel-read phase |

## Verification
The hardest situation to reach from the ports is an overlapping copy, where the engine reads pixels it has already overwritten. Whether the result comes out as a clean shift or as a smear depends only on the walk direction. The stimulus builds such copies on purpose: it shifts a row right by a few pixels, both forwards and with reverse x, and shifts rows down with and without reverse y. A pixel-exact model updated in walk order predicts both outcomes. The stalled-write case needs a long fill to be running while a pixel write is pushed at the port, and a full framebuffer read-back confirms that the write was not taken.

// File: rtl/blit_pkg.sv
package blit_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_RD_SRC,
        ST_RD_DST,
        ST_WR_PIX
    } blit_state_e;

    localparam logic [5:0] OP_NOP  = 6'h00;
    localparam logic [5:0] OP_COPY = 6'h01;
    localparam logic [5:0] OP_FILL = 6'h02;

    localparam logic [2:0] SEL_CTRL = 3'd0;
    localparam logic [2:0] SEL_SRC  = 3'd1;
    localparam logic [2:0] SEL_DST  = 3'd2;
    localparam logic [2:0] SEL_SIZE = 3'd3;
    localparam logic [2:0] SEL_FG   = 3'd4;
    localparam logic [2:0] SEL_ROP  = 3'd5;

    localparam int PITCH_W = 11;

    // Screen pitch in pixels for a pitch code; zero marks an unusable code.
    function automatic logic [PITCH_W-1:0] pitch_of(input logic [2:0] code);
        case (code)
            3'd1:    pitch_of = 11'd640;
            3'd2:    pitch_of = 11'd800;
            3'd4:    pitch_of = 11'd1024;
            3'd5:    pitch_of = 11'd1152;
            3'd6:    pitch_of = 11'd1280;
            3'd7:    pitch_of = 11'd1600;
            default: pitch_of = '0;
        endcase
    endfunction
endpackage

// File: rtl/blit_fb_ram.sv
module blit_fb_ram #(
    parameter int WORDS = 2048,
    parameter int DW    = 8,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/blit_rop.sv
module blit_rop #(
    parameter int DW = 8
) (
    input  logic [7:0]    code,
    input  logic [DW-1:0] pat,
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] dst,
    output logic [DW-1:0] res
);
    // Each result bit indexes the truth table with {pattern, source, dest}.
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign res[i] = code[{pat[i], src[i], dst[i]}];
    end
endmodule

// File: rtl/blit_stepper.sv
module blit_stepper #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [CW-1:0] width,
    input  logic [CW-1:0] height,
    output logic [CW-1:0] xi,
    output logic [CW-1:0] yi,
    output logic          last
);
    logic row_end;

    assign row_end = (xi == width - 1'b1);
    assign last    = row_end && (yi == height - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xi <= '0;
            yi <= '0;
        end else if (clear) begin
            xi <= '0;
            yi <= '0;
        end else if (step) begin
            if (row_end) begin
                xi <= '0;
                yi <= yi + 1'b1;
            end else begin
                xi <= xi + 1'b1;
            end
        end
    end
endmodule

// File: rtl/blit_addr.sv
module blit_addr #(
    parameter int CW = 16,
    parameter int PW = 11,
    parameter int AW = 11
) (
    input  logic [CW-1:0] base_x,
    input  logic [CW-1:0] base_y,
    input  logic [CW-1:0] xi,
    input  logic [CW-1:0] yi,
    input  logic          rev_x,
    input  logic          rev_y,
    input  logic [PW-1:0] pitch,
    output logic [AW-1:0] addr
);
    logic [CW-1:0]    px, py;
    logic [CW+PW-1:0] lin;

    always_comb begin
        px   = rev_x ? base_x - xi : base_x + xi;
        py   = rev_y ? base_y - yi : base_y + yi;
        lin  = {{PW{1'b0}}, py} * {{CW{1'b0}}, pitch} + {{PW{1'b0}}, px};
        addr = lin[AW-1:0];
    end
endmodule

// File: rtl/blit_engine.sv
module blit_engine
    import blit_pkg::*;
#(
    parameter int FB_WORDS = 2048,
    parameter int PIX_W    = 8,
    parameter int COORD_W  = 16,
    localparam int ADDR_W  = $clog2(FB_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic              pix_we,
    input  logic [ADDR_W-1:0] pix_addr,
    input  logic [PIX_W-1:0]  pix_wdata,
    output logic [PIX_W-1:0]  pix_rdata,
    output logic              host_ready,
    output logic [2:0]        status
);
    blit_state_e state, state_nx;

    logic [5:0]         cmd_q;
    logic               rev_x_q, rev_y_q;
    logic [2:0]         depth_q, pitch_code_q;
    logic [1:0]         quick_q;
    logic [COORD_W-1:0] src_x_q, src_y_q, dst_x_q, dst_y_q, wid_q, hgt_q;
    logic [PIX_W-1:0]   fg_q, src_pix_q;
    logic [7:0]         rop_q;

    logic               wr_ok, launch, is_copy, op_ok, last;
    logic [PITCH_W-1:0] pitch;
    logic [COORD_W-1:0] xi, yi;
    logic [ADDR_W-1:0]  src_addr, dst_addr, ram_addr;
    logic               ram_we;
    logic [PIX_W-1:0]   ram_wdata, ram_rdata, rop_out;

    assign wr_ok   = reg_we && host_ready;
    assign is_copy = (cmd_q == OP_COPY);
    assign pitch   = pitch_of(pitch_code_q);
    assign op_ok   = (is_copy || cmd_q == OP_FILL) && (pitch != '0) && (depth_q == 3'd1)
                     && (wid_q != '0) && (hgt_q != '0);

    // Register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0; rev_x_q <= 1'b0; rev_y_q <= 1'b0;
            depth_q <= '0; pitch_code_q <= '0; quick_q <= '0;
            src_x_q <= '0; src_y_q <= '0; dst_x_q <= '0; dst_y_q <= '0;
            wid_q <= '0; hgt_q <= '0; fg_q <= '0; rop_q <= '0;
        end else if (wr_ok) begin
            case (reg_sel)
                SEL_CTRL: begin
                    cmd_q        <= reg_wdata[5:0];
                    rev_x_q      <= reg_wdata[6];
                    rev_y_q      <= reg_wdata[7];
                    depth_q      <= reg_wdata[16:14];
                    pitch_code_q <= reg_wdata[26:24];
                    quick_q      <= reg_wdata[30:29];
                end
                SEL_SRC:  begin src_x_q <= reg_wdata[15:0]; src_y_q <= reg_wdata[31:16]; end
                SEL_DST:  begin dst_x_q <= reg_wdata[15:0]; dst_y_q <= reg_wdata[31:16]; end
                SEL_SIZE: begin wid_q   <= reg_wdata[15:0]; hgt_q   <= reg_wdata[31:16]; end
                SEL_FG:   fg_q  <= reg_wdata[PIX_W-1:0];
                SEL_ROP:  rop_q <= reg_wdata[7:0];
                default:  ;
            endcase
        end
    end

    // Launch decode: explicit start bit or the quick-start register
    always_comb begin
        launch = 1'b0;
        if (wr_ok) begin
            case (reg_sel)
                SEL_CTRL: launch = reg_wdata[31];
                SEL_SIZE: launch = (quick_q == 2'd1);
                SEL_SRC:  launch = (quick_q == 2'd2);
                SEL_DST:  launch = (quick_q == 2'd3);
                default:  launch = 1'b0;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (launch) state_nx = ST_LAUNCH;
            ST_LAUNCH: if (!op_ok)      state_nx = ST_IDLE;
                       else if (is_copy) state_nx = ST_RD_SRC;
                       else             state_nx = ST_RD_DST;
            ST_RD_SRC: state_nx = ST_RD_DST;
            ST_RD_DST: state_nx = ST_WR_PIX;
            ST_WR_PIX: if (last)         state_nx = ST_IDLE;
                       else if (is_copy) state_nx = ST_RD_SRC;
                       else             state_nx = ST_RD_DST;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Outputs: framebuffer port steering and status
    always_comb begin
        ram_addr  = pix_addr;
        ram_we    = 1'b0;
        ram_wdata = pix_wdata;
        unique case (state)
            ST_IDLE:   ram_we = pix_we;
            ST_LAUNCH: ram_we = 1'b0;
            ST_RD_SRC: ram_addr = src_addr;
            ST_RD_DST: ram_addr = dst_addr;
            ST_WR_PIX: begin
                ram_addr  = dst_addr;
                ram_we    = 1'b1;
                ram_wdata = rop_out;
            end
            default:   ram_we = 1'b0;
        endcase
        host_ready = (state == ST_IDLE);
        status     = {state != ST_IDLE, 1'b0,
                      (state == ST_RD_SRC) || (state == ST_RD_DST)};
    end

    // Source pixel holding register (copy only)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  src_pix_q <= '0;
        else if (state == ST_RD_DST) src_pix_q <= ram_rdata;
    end

    assign pix_rdata = ram_rdata;

    blit_stepper #(.CW(COORD_W)) u_step (
        .clk(clk), .rst_n(rst_n),
        .clear(state == ST_LAUNCH), .step(state == ST_WR_PIX),
        .width(wid_q), .height(hgt_q), .xi(xi), .yi(yi), .last(last)
    );

    blit_addr #(.CW(COORD_W), .PW(PITCH_W), .AW(ADDR_W)) u_src_addr (
        .base_x(src_x_q), .base_y(src_y_q), .xi(xi), .yi(yi),
        .rev_x(rev_x_q), .rev_y(rev_y_q), .pitch(pitch), .addr(src_addr)
    );

    blit_addr #(.CW(COORD_W), .PW(PITCH_W), .AW(ADDR_W)) u_dst_addr (
        .base_x(dst_x_q), .base_y(dst_y_q), .xi(xi), .yi(yi),
        .rev_x(rev_x_q), .rev_y(rev_y_q), .pitch(pitch), .addr(dst_addr)
    );

    blit_rop #(.DW(PIX_W)) u_rop (
        .code(rop_q), .pat(fg_q), .src(is_copy ? src_pix_q : fg_q),
        .dst(ram_rdata), .res(rop_out)
    );

    blit_fb_ram #(.WORDS(FB_WORDS), .DW(PIX_W)) u_fb (
        .clk(clk), .we(ram_we), .addr(ram_addr),
        .wdata(ram_wdata), .rdata(ram_rdata)
    );
endmodule

// File: rtl/blit_checker.sv
module blit_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       host_ready,
    input logic [2:0] status,
    input logic       reg_we,
    input logic [2:0] reg_sel,
    input logic [1:0] quick,
    input logic       eng_we
);
    AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ready |-> status[2]); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> status == 3'b000); // R11

    AST_SIZE_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && host_ready && reg_sel == 3'd3 && quick == 2'd1) |=> !host_ready); // R4

    AST_FG_NO_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && host_ready && reg_sel == 3'd4) |=> host_ready); // R4

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> $past(status[0])); // R5

    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |=> !eng_we); // R5
endmodule

bind blit_engine blit_checker u_chk (
    .clk(clk), .rst_n(rst_n), .host_ready(host_ready), .status(status),
    .reg_we(reg_we), .reg_sel(reg_sel), .quick(quick_q),
    .eng_we(ram_we && !host_ready)
);

// File: tb/tb_blit_engine.sv
`timescale 1ns/1ps
module tb_blit_engine;
    localparam int WORDS = 2048;
    localparam int AW    = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic [31:0]   reg_wdata = '0;
    logic          pix_we = 1'b0;
    logic [AW-1:0] pix_addr = '0;
    logic [7:0]    pix_wdata = '0;
    logic [7:0]    pix_rdata;
    logic          host_ready;
    logic [2:0]    status;

    logic [7:0] mdl [WORDS];
    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    blit_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .pix_we(pix_we), .pix_addr(pix_addr),
        .pix_wdata(pix_wdata), .pix_rdata(pix_rdata),
        .host_ready(host_ready), .status(status)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++; checks++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int pitch_f(input int code);
        case (code)
            1: return 640;  2: return 800;  4: return 1024;
            5: return 1152; 6: return 1280; 7: return 1600;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] rop_f(input logic [7:0] r, input logic [7:0] p,
                                         input logic [7:0] s, input logic [7:0] d);
        logic [7:0] o;
        for (int i = 0; i < 8; i++) o[i] = r[4*p[i] + 2*s[i] + d[i]];
        return o;
    endfunction

    task automatic wait_ready();
        @(negedge clk);
        while (!host_ready) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [31:0] data);
        wait_ready();
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pix_write(input int a, input logic [7:0] d);
        wait_ready();
        pix_we = 1'b1; pix_addr = AW'(a); pix_wdata = d;
        @(negedge clk);
        pix_we = 1'b0;
    endtask

    task automatic compare_all(input string req);
        int bad = 0; int ba = 0; logic [7:0] bact = '0; logic [7:0] bexp = '0;
        wait_ready();
        pix_addr = '0;
        for (int a = 0; a < WORDS; a++) begin
            @(negedge clk);
            if (pix_rdata !== mdl[a]) begin
                if (bad == 0) begin ba = a; bact = pix_rdata; bexp = mdl[a]; end
                bad++;
            end
            pix_addr = AW'(a + 1);
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s: addr %0d actual %0h expected %0h (%0d bad)", req, ba, bact, bexp, bad);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input int cmd, input bit rx, input bit ry,
            input int dep, input int pc, input int q, input bit st);
        logic [31:0] c = '0;
        c[5:0] = 6'(cmd); c[6] = rx; c[7] = ry; c[16:14] = 3'(dep);
        c[26:24] = 3'(pc); c[30:29] = 2'(q); c[31] = st;
        return c;
    endfunction

    task automatic model_op(input int cmd, input bit rx, input bit ry,
            input logic [15:0] sx, input logic [15:0] sy, input logic [15:0] dx,
            input logic [15:0] dy, input int w, input int h, input logic [7:0] fg,
            input logic [7:0] rop, input int pc, input int dep);
        int p = pitch_f(pc);
        if (!((cmd == 1 || cmd == 2) && p != 0 && dep == 1 && w != 0 && h != 0)) return;
        for (int yi = 0; yi < h; yi++)
            for (int xi = 0; xi < w; xi++) begin
                logic [15:0] ax, ay, bx, by; int sa, da; logic [7:0] s;
                ax = rx ? sx - 16'(xi) : sx + 16'(xi);
                ay = ry ? sy - 16'(yi) : sy + 16'(yi);
                bx = rx ? dx - 16'(xi) : dx + 16'(xi);
                by = ry ? dy - 16'(yi) : dy + 16'(yi);
                sa = (int'(ay) * p + int'(ax)) & (WORDS - 1);
                da = (int'(by) * p + int'(bx)) & (WORDS - 1);
                s  = (cmd == 1) ? mdl[sa] : fg;
                mdl[da] = rop_f(rop, fg, s, mdl[da]);
            end
    endtask

    // mode 0: explicit start; 1..3: quick-start on size, source, destination
    task automatic run_op(input int cmd, input bit rx, input bit ry,
            input logic [15:0] sx, input logic [15:0] sy, input logic [15:0] dx,
            input logic [15:0] dy, input int w, input int h, input logic [7:0] fg,
            input logic [7:0] rop, input int pc, input int dep, input int mode,
            input string req);
        logic [31:0] s_w = {sy, sx};
        logic [31:0] d_w = {dy, dx};
        logic [31:0] z_w = {16'(h), 16'(w)};
        bit valid = (cmd == 1 || cmd == 2) && pitch_f(pc) != 0 && dep == 1 && w != 0 && h != 0;
        wr_reg(3'd0, mk_ctrl(cmd, rx, ry, dep, pc, mode, 1'b0));
        wr_reg(3'd4, {24'd0, fg});
        wr_reg(3'd5, {24'd0, rop});
        case (mode)
            0: begin
                wr_reg(3'd1, s_w); wr_reg(3'd2, d_w); wr_reg(3'd3, z_w);
                wr_reg(3'd0, mk_ctrl(cmd, rx, ry, dep, pc, 0, 1'b1));
            end
            1: begin wr_reg(3'd1, s_w); wr_reg(3'd2, d_w); wr_reg(3'd3, z_w); end
            2: begin
                wr_reg(3'd2, d_w);
                chk(host_ready == 1'b1, "R4 dst write must not launch in mode 2", host_ready, 1);
                wr_reg(3'd3, z_w); wr_reg(3'd1, s_w);
            end
            default: begin wr_reg(3'd1, s_w); wr_reg(3'd3, z_w); wr_reg(3'd2, d_w); end
        endcase
        if (valid) begin
            chk(host_ready == 1'b0 && status == 3'b100, "R11 busy after launch", status, 3'b100);
            @(negedge clk);
            chk(status == 3'b101, "R11 read phase flag", status, 3'b101);
        end else begin
            @(negedge clk);
            chk(host_ready == 1'b1, req, host_ready, 1);
        end
        model_op(cmd, rx, ry, sx, sy, dx, dy, w, h, fg, rop, pc, dep);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(host_ready == 1'b1, "R1 ready at reset", host_ready, 1);
        chk(status == 3'b000, "R1 status at reset", status, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_ready == 1'b1 && status == 3'b000, "R1 after reset release", status, 0);

        for (int a = 0; a < WORDS; a++) begin
            logic [7:0] v = 8'($urandom);
            mdl[a] = v;
            pix_write(a, v);
        end
        compare_all("R12 pixel port load");

        // R3 R5 explicit start, plain copy
        run_op(1, 0, 0, 16'd10, 16'd0, 16'd300, 16'd1, 5, 2, 8'h00, 8'hCC, 1, 1, 0, "");
        compare_all("R3 R5 R2 copy");
        // R6 fill with pattern code
        run_op(2, 0, 0, 16'd0, 16'd0, 16'd50, 16'd2, 7, 3, 8'h5A, 8'hF0, 1, 1, 1, "");
        compare_all("R6 fill");
        // R5 forward overlapping copy (smear)
        run_op(1, 0, 0, 16'd100, 16'd0, 16'd102, 16'd0, 6, 1, 8'h00, 8'hCC, 1, 1, 2, "");
        compare_all("R5 forward overlap");
        // R7 reverse x overlapping copy (clean shift)
        run_op(1, 1, 0, 16'd205, 16'd0, 16'd207, 16'd0, 6, 1, 8'h00, 8'hCC, 1, 1, 3, "");
        compare_all("R7 reverse x");
        // R7 reverse y overlapping row copy
        run_op(1, 0, 1, 16'd400, 16'd2, 16'd400, 16'd3, 4, 2, 8'h00, 8'hCC, 1, 1, 0, "");
        compare_all("R7 reverse y");
        // R8 inverted source and three-way xor
        run_op(1, 0, 0, 16'd20, 16'd1, 16'd500, 16'd0, 4, 2, 8'h00, 8'h33, 2, 1, 1, "");
        compare_all("R8 rop 33");
        run_op(1, 0, 0, 16'd30, 16'd1, 16'd520, 16'd0, 4, 2, 8'hC3, 8'h96, 4, 1, 0, "");
        compare_all("R8 rop 96");
        // R9 rejected launches
        run_op(0, 0, 0, 16'd0, 16'd0, 16'd0, 16'd0, 4, 4, 8'hFF, 8'hF0, 1, 1, 0, "R9 nop ready");
        run_op(2, 0, 0, 16'd0, 16'd0, 16'd0, 16'd0, 4, 4, 8'hFF, 8'hF0, 3, 1, 1, "R9 pitch code ready");
        run_op(2, 0, 0, 16'd0, 16'd0, 16'd0, 16'd0, 4, 4, 8'hFF, 8'hF0, 1, 2, 0, "R9 depth ready");
        compare_all("R9 no change");
        // R10 empty rectangles
        run_op(2, 0, 0, 16'd0, 16'd0, 16'd0, 16'd0, 0, 4, 8'hFF, 8'hF0, 1, 1, 1, "R10 zero width ready");
        run_op(1, 0, 0, 16'd0, 16'd0, 16'd9, 16'd0, 4, 0, 8'hFF, 8'hCC, 1, 1, 3, "R10 zero height ready");
        compare_all("R10 no change");
        // R11 write presented while busy is not taken
        run_op(2, 0, 0, 16'd0, 16'd0, 16'd0, 16'd0, 8, 3, 8'h11, 8'hF0, 1, 1, 1, "");
        chk(host_ready == 1'b0, "R11 still busy", host_ready, 0);
        pix_we = 1'b1; pix_addr = AW'(2000); pix_wdata = ~mdl[2000];
        @(negedge clk);
        pix_we = 1'b0;
        compare_all("R11 stalled write dropped");

        // randomized operations
        for (int n = 0; n < 24; n++) begin
            int pcs [6] = '{1, 2, 4, 5, 6, 7};
            int ropsel = int'($urandom % 4);
            logic [7:0] r = (ropsel == 0) ? 8'hCC : (ropsel == 1) ? 8'hF0 :
                            (ropsel == 2) ? 8'h33 : 8'($urandom);
            run_op(1 + int'($urandom % 2), 1'($urandom), 1'($urandom),
                   16'($urandom % 1000), 16'($urandom % 5),
                   16'($urandom % 1000), 16'($urandom % 5),
                   1 + int'($urandom % 8), 1 + int'($urandom % 4),
                   8'($urandom), r, pcs[$urandom % 6], 1, int'($urandom % 4), "");
            compare_all("R5 R6 R7 R8 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule